// File: doc/BRIEF.md
# Fetch Program Counter Generator

This block produces the instruction-memory address for a five-stage scalar pipeline and tracks which instruction sits in decode. On each cycle it presents the current program counter to a single-cycle synchronous instruction memory. The word read at that address comes back on the next cycle and becomes the decode-stage instruction. Normally the counter advances by one 32-bit instruction (4 bytes). The block also contains the decode-stage branch resolution: a full-width equality compare of the two register operands, and a target adder that adds a byte offset to the address of the instruction in decode. Branches are treated as not taken until decode resolves them. When decode finds a taken branch or jump, the word already being fetched behind it is discarded, so a taken branch costs one cycle.

An exception redirect from the end of the pipeline loads a fixed handler address and discards the word in flight. The order of precedence is exception first, then a taken branch or jump, then a stall request, and last the normal increment. A stall freezes the counter, the decode slot and the memory read enable. Decode branch information is only acted on when the decode slot holds a valid instruction.

Top module: `fetch_pc_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `fetch_addr_o` equals the reset address (default 0x0000_0000), and `fetch_valid_o` and `flush_o` are 0.
- R2: With no stall, no exception and no taken branch, the next cycle's `fetch_addr_o` is the current value plus 4, `fetch_valid_o` becomes 1, and `dec_pc_o` takes the address that was just fetched.
- R3: A stall with no redirect keeps `fetch_addr_o`, `fetch_valid_o` and `dec_pc_o` unchanged in the next cycle and drives `fetch_en_o` low, so the memory output also holds.
- R4: Branch kind code 1 (branch-if-equal) on a valid decode slot is taken when all 32 bits of the two operands match. `flush_o` is then 1 in that cycle. The next `fetch_addr_o` is `dec_pc_o + dec_offset_i` with bits 1:0 forced to 0, and `fetch_valid_o` is 0 in the next cycle.
- R5: Kind code 2 (branch-if-not-equal) is taken when the operands differ in any bit. Kind 1 with operands that differ, or kind 2 with operands that are equal, falls through to the +4 path.
- R6: Kind code 3 (jump) on a valid decode slot is always taken. Kind code 0 never redirects.
- R7: When `fetch_valid_o` is 0, the decode branch inputs have no effect: `flush_o` stays 0 and the address follows the stall or +4 rule.
- R8: `exc_i` makes the next `fetch_addr_o` the handler address (default 0x0000_0080) whatever the branch or stall inputs are. It also raises `flush_o` in the same cycle and clears `fetch_valid_o` in the next cycle.
- R9: A redirect (exception or taken branch) overrides a stall: the counter is loaded and `fetch_en_o` is 1.
- R10: When `fetch_valid_o` is 1, the memory word in decode is the one read from address `dec_pc_o`.
- R11: Address arithmetic wraps modulo 2^32, so after 0xFFFF_FFFC the next sequential address is 0x0000_0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Hold fetch and decode this cycle |
| exc_i | input | 1 | Exception redirect from the last stage |
| dec_kind_i | input | 2 | Decode control-flow kind: 0 none, 1 branch-if-equal, 2 branch-if-not-equal, 3 jump |
| dec_opa_i | input | 32 | First register operand read in decode |
| dec_opb_i | input | 32 | Second register operand read in decode |
| dec_offset_i | input | 32 | Signed byte offset of the branch or jump target |
| fetch_addr_o | output | 32 | Address presented to instruction memory |
| fetch_en_o | output | 1 | Instruction memory read enable |
| fetch_valid_o | output | 1 | The decode slot holds a valid instruction |
| dec_pc_o | output | 32 | Address of the instruction in decode |
| flush_o | output | 1 | The word being fetched this cycle is discarded |

## Verification
Internal state here is only the counter and the decode slot, and both are outputs. A wrong priority, a wrong compare or a missed hold therefore shows up on `fetch_addr_o` or `fetch_valid_o` on the very next clock edge. A wrong `flush_o` or `fetch_en_o` shows up in the same cycle. A counter that loses its link to the memory read shows up one cycle later, as a decode word that does not match `dec_pc_o`. The bench's behavioural model predicts all five outputs every cycle, so a fault is caught within one cycle of the input pattern that triggers it.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    // Control-flow kind reported by decode for the instruction it holds.
    typedef enum logic [1:0] {
        CF_NONE = 2'd0,
        CF_BEQ  = 2'd1,
        CF_BNE  = 2'd2,
        CF_JUMP = 2'd3
    } cf_kind_e;

    // Where the next program counter comes from, highest priority last.
    typedef enum logic [1:0] {
        NPC_SEQ  = 2'd0,
        NPC_HOLD = 2'd1,
        NPC_BR   = 2'd2,
        NPC_EXC  = 2'd3
    } npc_src_e;

endpackage

// File: rtl/fetch_eq_cmp.sv
// Equality compare of two operands, split into lanes that are
// reduced separately and then combined.
module fetch_eq_cmp #(
    parameter int W    = 32,
    parameter int LANE = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         eq_o
);
    localparam int NLANE = (W + LANE - 1) / LANE;

    logic [NLANE-1:0] lane_eq;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LO = g * LANE;
        localparam int HI = ((LO + LANE) > W) ? (W - 1) : (LO + LANE - 1);
        assign lane_eq[g] = (a_i[HI:LO] == b_i[HI:LO]);
    end

    assign eq_o = &lane_eq;
endmodule

// File: rtl/fetch_tgt_add.sv
// Branch/jump target: decode PC plus byte offset, forced to instruction alignment.
module fetch_tgt_add #(
    parameter int W          = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] off_i,
    output logic [W-1:0] tgt_o
);
    localparam logic [W-1:0] ALIGN_MASK = ~((W'(1) << ALIGN_BITS) - W'(1));

    logic [W-1:0] sum;

    always_comb begin
        sum   = base_i + off_i;
        tgt_o = sum & ALIGN_MASK;
    end
endmodule

// File: rtl/fetch_redirect_sel.sv
// Picks the source of the next program counter by fixed priority.
module fetch_redirect_sel
    import fetch_pkg::*;
(
    input  logic     exc_i,
    input  logic     dec_valid_i,
    input  logic     stall_i,
    input  cf_kind_e kind_i,
    input  logic     ops_eq_i,
    output npc_src_e src_o,
    output logic     redirect_o
);
    logic br_taken;

    always_comb begin
        unique case (kind_i)
            CF_BEQ:  br_taken = ops_eq_i;
            CF_BNE:  br_taken = !ops_eq_i;
            CF_JUMP: br_taken = 1'b1;
            default: br_taken = 1'b0;
        endcase
        br_taken = br_taken && dec_valid_i;

        if (exc_i) begin
            src_o = NPC_EXC;
        end else if (br_taken) begin
            src_o = NPC_BR;
        end else if (stall_i) begin
            src_o = NPC_HOLD;
        end else begin
            src_o = NPC_SEQ;
        end

        redirect_o = (src_o == NPC_EXC) || (src_o == NPC_BR);
    end
endmodule

// File: rtl/fetch_pc_gen.sv
module fetch_pc_gen
    import fetch_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          INSTR_BYTES = 4,
    parameter int          CMP_LANE    = 8,
    parameter logic [31:0] RESET_PC    = 32'h0000_0000,
    parameter logic [31:0] HANDLER_PC  = 32'h0000_0080
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall_i,
    input  logic            exc_i,
    input  logic [1:0]      dec_kind_i,
    input  logic [XLEN-1:0] dec_opa_i,
    input  logic [XLEN-1:0] dec_opb_i,
    input  logic [XLEN-1:0] dec_offset_i,
    output logic [XLEN-1:0] fetch_addr_o,
    output logic            fetch_en_o,
    output logic            fetch_valid_o,
    output logic [XLEN-1:0] dec_pc_o,
    output logic            flush_o
);
    localparam int            ALIGN_BITS = $clog2(INSTR_BYTES);
    localparam logic [XLEN-1:0] STEP     = XLEN'(INSTR_BYTES);
    localparam logic [XLEN-1:0] PC_RST   = XLEN'(RESET_PC);
    localparam logic [XLEN-1:0] PC_EXC   = XLEN'(HANDLER_PC);

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] dpc;
        logic            dvalid;
    } fetch_state_t;

    fetch_state_t st_d, st_q;

    logic            ops_eq;
    logic [XLEN-1:0] br_tgt;
    npc_src_e        npc_src;
    logic            redirect;

    fetch_eq_cmp #(
        .W    (XLEN),
        .LANE (CMP_LANE)
    ) u_cmp (
        .a_i  (dec_opa_i),
        .b_i  (dec_opb_i),
        .eq_o (ops_eq)
    );

    fetch_tgt_add #(
        .W          (XLEN),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_tgt (
        .base_i (st_q.dpc),
        .off_i  (dec_offset_i),
        .tgt_o  (br_tgt)
    );

    fetch_redirect_sel u_sel (
        .exc_i       (exc_i),
        .dec_valid_i (st_q.dvalid),
        .stall_i     (stall_i),
        .kind_i      (cf_kind_e'(dec_kind_i)),
        .ops_eq_i    (ops_eq),
        .src_o       (npc_src),
        .redirect_o  (redirect)
    );

    always_comb begin
        st_d = st_q;
        unique case (npc_src)
            NPC_EXC: begin
                st_d.pc     = PC_EXC;
                st_d.dpc    = st_q.pc;
                st_d.dvalid = 1'b0;
            end
            NPC_BR: begin
                st_d.pc     = br_tgt;
                st_d.dpc    = st_q.pc;
                st_d.dvalid = 1'b0;
            end
            NPC_HOLD: begin
                st_d = st_q;
            end
            default: begin
                st_d.pc     = st_q.pc + STEP;
                st_d.dpc    = st_q.pc;
                st_d.dvalid = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc     <= PC_RST;
            st_q.dpc    <= PC_RST;
            st_q.dvalid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr_o  = st_q.pc;
    assign dec_pc_o      = st_q.dpc;
    assign fetch_valid_o = st_q.dvalid;
    assign flush_o       = redirect;
    assign fetch_en_o    = redirect || !stall_i;
endmodule

// File: rtl/fetch_pc_gen_chk.sv
module fetch_pc_gen_chk #(
    parameter int          XLEN       = 32,
    parameter logic [31:0] HANDLER_PC = 32'h0000_0080
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall_i,
    input logic            exc_i,
    input logic [XLEN-1:0] fetch_addr_o,
    input logic            fetch_en_o,
    input logic            fetch_valid_o,
    input logic [XLEN-1:0] dec_pc_o,
    input logic            flush_o
);
    // R2: plain advance steps the address by one instruction
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !flush_o) |=> (fetch_addr_o == $past(fetch_addr_o) + XLEN'(4)));

    // R10: the advanced decode slot carries the address just fetched
    p_dpc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !flush_o) |=> (fetch_valid_o && dec_pc_o == $past(fetch_addr_o)));

    // R3: stall without redirect freezes the address and decode slot
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !flush_o) |=> ($stable(fetch_addr_o) && $stable(dec_pc_o) && $stable(fetch_valid_o)));

    // R3: no memory read during a plain stall
    p_noread_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !flush_o) |-> !fetch_en_o);

    // R8: exception lands on the handler with an empty decode slot
    p_exc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_i |=> (fetch_addr_o == XLEN'(HANDLER_PC) && !fetch_valid_o));

    // R8: exception always discards the word in flight
    p_exc_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_i |-> flush_o);

    // R4: discarded word never reaches decode as valid
    p_squash_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !fetch_valid_o);

    // R7: an empty decode slot cannot cause a branch redirect
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid_o && !exc_i) |-> !flush_o);

    // R9: a redirect always reads memory
    p_redir_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> fetch_en_o);
endmodule

bind fetch_pc_gen fetch_pc_gen_chk #(
    .XLEN       (XLEN),
    .HANDLER_PC (HANDLER_PC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_i       (stall_i),
    .exc_i         (exc_i),
    .fetch_addr_o  (fetch_addr_o),
    .fetch_en_o    (fetch_en_o),
    .fetch_valid_o (fetch_valid_o),
    .dec_pc_o      (dec_pc_o),
    .flush_o       (flush_o)
);

// File: tb/fetch_pc_gen_test.sv
`timescale 1ns/1ps
module fetch_pc_gen_test;
    localparam logic [31:0] RST_ADDR = 32'h0000_0000;
    localparam logic [31:0] HND_ADDR = 32'h0000_0080;
    localparam logic [31:0] SALT     = 32'hA5A5_3C3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        exc = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic [31:0] opa = '0, opb = '0, offs = '0;
    logic [31:0] fetch_addr, dec_pc;
    logic        fetch_en, fetch_valid, flush;
    logic [31:0] imem_q;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_pc = RST_ADDR;
    logic [31:0] m_dpc = RST_ADDR;
    logic        m_valid = 1'b0;

    always #5 clk = ~clk;

    fetch_pc_gen uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .stall_i       (stall),
        .exc_i         (exc),
        .dec_kind_i    (kind),
        .dec_opa_i     (opa),
        .dec_opb_i     (opb),
        .dec_offset_i  (offs),
        .fetch_addr_o  (fetch_addr),
        .fetch_en_o    (fetch_en),
        .fetch_valid_o (fetch_valid),
        .dec_pc_o      (dec_pc),
        .flush_o       (flush)
    );

    // single-cycle synchronous instruction memory, contents derived from address
    always_ff @(posedge clk) begin
        if (fetch_en) imem_q <= fetch_addr ^ SALT;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Applies one cycle of inputs (called just after a falling edge), checks, advances model.
    task automatic step(input logic s, input logic e, input logic [1:0] k,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] off);
        logic taken, x_flush, x_en;
        stall = s; exc = e; kind = k; opa = a; opb = b; offs = off;
        #1;
        taken = 1'b0;
        if (m_valid && !e) begin
            if (k == 2'd3) taken = 1'b1;
            else if (k == 2'd1) taken = (a == b);
            else if (k == 2'd2) taken = (a != b);
        end
        x_flush = e || taken;
        x_en    = x_flush || !s;
        chk(fetch_addr == m_pc, "R2 R4 R6 R8 R11 fetch address", fetch_addr, m_pc);
        chk(fetch_valid == m_valid, "R2 R3 R7 decode valid", 32'(fetch_valid), 32'(m_valid));
        chk(flush == x_flush, "R4 R5 R6 R7 R8 flush", 32'(flush), 32'(x_flush));
        chk(fetch_en == x_en, "R3 R9 fetch enable", 32'(fetch_en), 32'(x_en));
        if (m_valid) begin
            chk(dec_pc == m_dpc, "R10 decode address", dec_pc, m_dpc);
            chk(imem_q == (m_dpc ^ SALT), "R10 decode word", imem_q, m_dpc ^ SALT);
        end
        if (e) begin
            m_dpc = m_pc; m_pc = HND_ADDR; m_valid = 1'b0;
        end else if (taken) begin
            logic [31:0] t;
            t = (m_dpc + off) & 32'hFFFF_FFFC;
            m_dpc = m_pc; m_pc = t; m_valid = 1'b0;
        end else if (!s) begin
            m_dpc = m_pc; m_pc = m_pc + 32'd4; m_valid = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 32'd0, 32'd0, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: values while reset is held
        chk(fetch_addr == RST_ADDR, "R1 reset address", fetch_addr, RST_ADDR);
        chk(fetch_valid == 1'b0, "R1 reset valid", 32'(fetch_valid), 32'd0);
        chk(flush == 1'b0, "R1 reset flush", 32'(flush), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        idle(4);                                                   // R2 sequential
        step(1'b1, 1'b0, 2'd0, 0, 0, 0);                           // R3 stall
        step(1'b1, 1'b0, 2'd0, 0, 0, 0);
        idle(1);
        step(1'b0, 1'b0, 2'd1, 32'h1234_5678, 32'h1234_5678, 32'h40); // R4 beq taken
        step(1'b0, 1'b0, 2'd3, 0, 0, 32'h100);                     // R7 empty slot ignored
        idle(1);
        step(1'b0, 1'b0, 2'd1, 32'h8000_0001, 32'h0000_0001, 32'h40); // R5 beq differs in bit 31
        step(1'b0, 1'b0, 2'd2, 32'h5, 32'h5, 32'h40);              // R5 bne equal
        step(1'b0, 1'b0, 2'd2, 32'h5, 32'h4, 32'hFFFF_FFF8);       // R5 bne taken, back 8
        idle(2);
        step(1'b0, 1'b0, 2'd0, 32'h7, 32'h7, 32'h40);              // R6 kind 0 never redirects
        step(1'b1, 1'b0, 2'd3, 0, 0, 32'h23);                      // R6 R9 jump under stall, misaligned
        idle(2);
        step(1'b0, 1'b1, 2'd3, 0, 0, 32'h200);                     // R8 exception beats jump
        idle(2);
        step(1'b1, 1'b1, 2'd0, 0, 0, 0);                           // R8 R9 exception beats stall
        idle(2);
        // R11: jump to the top word, then wrap
        step(1'b0, 1'b0, 2'd3, 0, 0, 32'hFFFF_FFFC - m_dpc);
        chk(fetch_addr == 32'hFFFF_FFFC, "R11 top address", fetch_addr, 32'hFFFF_FFFC);
        idle(1);
        chk(fetch_addr == 32'h0000_0000, "R11 wrapped address", fetch_addr, 32'h0);
        idle(2);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = ($urandom % 2 == 0) ? ra : (ra ^ (32'd1 << ($urandom % 32)));
            step(($urandom % 4) == 0, ($urandom % 16) == 0, 2'($urandom % 4),
                 ra, rb, (32'($urandom % 64) * 32'd4) - 32'd128);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule